// File: doc/BRIEF.md
# Privileged Status and Interrupt Register File

This block holds the machine-level status word, the interrupt enable, pending and delegation registers, the exception delegation register, both trap vectors and the scratch, exception-PC, cause and trap-value registers for the machine and supervisor levels. A single access port carries a 12-bit register number, a write strobe and write data. Reads return data in the same cycle. Writes take effect at the next rising clock edge.

Each register applies its own mask of writable bits. The supervisor status, interrupt-enable and interrupt-pending registers have no storage of their own. Each one is a masked window onto the machine register behind it. The summary dirty bit in the top position of the status word is never stored. It is derived from the floating-point and extension state fields whenever the register is read. A write that changes any status bit relevant to address translation raises a one-cycle flush request for the translation cache. A number that matches no implemented register raises an illegal flag, and the write is discarded.

Top module: `priv_csr_unit`

## Requirements
- R1: After reset, every implemented register reads zero and `tlb_flush` is low.
- R2: The machine pending register (0x344) stores software writes only in bits 1 and 5. Bits 3, 7, 9 and 11 read the live values of `hw_msip`, `hw_mtip`, `hw_seip` and `hw_meip`. All other bits read zero.
- R3: Only bits 1, 5 and 9 of the interrupt delegation register (0x303) are writable. Only bits 1, 3, 5, 7 and 9 of the machine enable register (0x304) are writable.
- R4: Writing the machine status word (0x300) updates only bits 1, 3, 5, 7, 8, 11 to 14 and 17 to 22. Bit XLEN-1 reads 1 exactly when bits 14:13 or bits 16:15 are both one. Writes to bit XLEN-1 have no effect.
- R5: Bits 16:15 of the status word can be written only when HAS_EXT is 1. When HAS_EXT is 0 they read zero.
- R6: `tlb_flush` is high for exactly the one cycle after a write to 0x300 or 0x100 that changes any of status bits 11, 12, 17, 18 or 19.
- R7: The supervisor status view (0x100) reads the status bits 1, 5, 8, 13 to 16 and 18, plus the derived bit XLEN-1. A write through it changes only those bits, still subject to the R4 and R5 masks.
- R8: Reading 0x144 returns the pending value AND the delegation register. Reading 0x104 returns the enable value AND the delegation register. A write to 0x144 changes only pending bit 1, and only while delegation bit 1 is set. A write to 0x104 replaces only the enable bits that are set in the delegation register.
- R9: A write to the supervisor vector (0x105) clears bits 1:0. A write to the machine vector (0x305) clears bit 1 and keeps bit 0.
- R10: In the exception delegation register (0x302), only bits 0 to 9, 11, 12, 13 and 15 are writable.
- R11: An access to any other register number raises `csr_illegal` in the same cycle and returns zero read data. The write is ignored.
- R12: Scratch, exception-PC, cause and trap-value registers (0x340 to 0x343 and 0x140 to 0x143) store the full written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Access strobe |
| csr_we | input | 1 | Write enable, qualified by csr_valid |
| csr_addr | input | 12 | Register number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the current access |
| csr_illegal | output | 1 | Access to an unimplemented number |
| hw_msip | input | 1 | Machine software interrupt line |
| hw_mtip | input | 1 | Machine timer interrupt line |
| hw_seip | input | 1 | Supervisor external interrupt line |
| hw_meip | input | 1 | Machine external interrupt line |
| tlb_flush | output | 1 | One-cycle translation flush request |

## Verification
The hardest cases to reach from the ports are the aliased supervisor windows. Their result depends on the delegation contents together with the earlier state of the machine registers. For that reason the bench first sets each delegation pattern in turn, then writes through the supervisor alias and reads both the alias and the machine register. The flush pulse is tested by writing each status bit alone, both setting it and clearing it, so that bits relevant to translation and bits that are not are both covered. A second instance with the extension field enabled shares the same stimulus, so the derived dirty bit can be reached through either field.

// File: rtl/priv_csr_unit.sv
module priv_csr_unit #(
  parameter int XLEN    = 32,
  parameter int HAS_EXT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_valid,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic            hw_msip,
  input  logic            hw_mtip,
  input  logic            hw_seip,
  input  logic            hw_meip,
  output logic            tlb_flush
);
  localparam logic [11:0] A_S_STAT = 12'h100, A_S_IE = 12'h104, A_S_VEC = 12'h105,
                          A_S_SCR = 12'h140, A_S_EPC = 12'h141, A_S_CAU = 12'h142,
                          A_S_TVAL = 12'h143, A_S_IP = 12'h144,
                          A_M_STAT = 12'h300, A_M_EDEL = 12'h302, A_M_IDEL = 12'h303,
                          A_M_IE = 12'h304, A_M_VEC = 12'h305, A_M_SCR = 12'h340,
                          A_M_EPC = 12'h341, A_M_CAU = 12'h342, A_M_TVAL = 12'h343,
                          A_M_IP = 12'h344;

  localparam logic [XLEN-1:0] EXT_FIELD  = XLEN'(32'h0001_8000);
  localparam logic [XLEN-1:0] STAT_WMASK = XLEN'(32'h007E_79AA) | ((HAS_EXT != 0) ? EXT_FIELD : '0);
  localparam logic [XLEN-1:0] SVIEW_MASK = XLEN'(32'h0005_E122);
  localparam logic [XLEN-1:0] XLATE_MASK = XLEN'(32'h000E_1800);
  localparam logic [XLEN-1:0] DELEG_MASK = XLEN'(32'h0000_0222);
  localparam logic [XLEN-1:0] IE_MASK    = XLEN'(32'h0000_02AA);
  localparam logic [XLEN-1:0] IPSW_MASK  = XLEN'(32'h0000_0022);
  localparam logic [XLEN-1:0] EDEL_MASK  = XLEN'(32'h0000_BBFF);
  localparam logic [XLEN-1:0] SSIP_BIT   = XLEN'(32'h0000_0002);

  logic [XLEN-1:0] status_q, ie_q, ipsw_q, ideleg_q, edeleg_q, mvec_q, svec_q;
  logic [XLEN-1:0] mscr_q, mepc_q, mcau_q, mtval_q, sscr_q, sepc_q, scau_q, stval_q;
  logic            flush_q;

  logic            dirty;
  logic [XLEN-1:0] status_rd, ip_view, stat_src, stat_new;
  logic            hit, wr, stat_wr;

  assign dirty     = (status_q[14:13] == 2'b11) || (status_q[16:15] == 2'b11);
  assign status_rd = status_q | (XLEN'(dirty) << (XLEN - 1));
  assign ip_view   = ipsw_q | (XLEN'(hw_msip) << 3) | (XLEN'(hw_mtip) << 7)
                   | (XLEN'(hw_seip) << 9) | (XLEN'(hw_meip) << 11);

  always_comb begin
    hit = 1'b1;
    csr_rdata = '0;
    unique case (csr_addr)
      A_S_STAT: csr_rdata = status_rd & (SVIEW_MASK | (XLEN'(1) << (XLEN - 1)));
      A_S_IE:   csr_rdata = ie_q & ideleg_q;
      A_S_IP:   csr_rdata = ip_view & ideleg_q;
      A_S_VEC:  csr_rdata = svec_q;
      A_S_SCR:  csr_rdata = sscr_q;
      A_S_EPC:  csr_rdata = sepc_q;
      A_S_CAU:  csr_rdata = scau_q;
      A_S_TVAL: csr_rdata = stval_q;
      A_M_STAT: csr_rdata = status_rd;
      A_M_EDEL: csr_rdata = edeleg_q;
      A_M_IDEL: csr_rdata = ideleg_q;
      A_M_IE:   csr_rdata = ie_q;
      A_M_IP:   csr_rdata = ip_view;
      A_M_VEC:  csr_rdata = mvec_q;
      A_M_SCR:  csr_rdata = mscr_q;
      A_M_EPC:  csr_rdata = mepc_q;
      A_M_CAU:  csr_rdata = mcau_q;
      A_M_TVAL: csr_rdata = mtval_q;
      default:  hit = 1'b0;
    endcase
    if (!csr_valid) csr_rdata = '0;
  end

  assign csr_illegal = csr_valid && !hit;
  assign wr          = csr_valid && csr_we && hit;
  assign stat_wr     = wr && (csr_addr == A_M_STAT || csr_addr == A_S_STAT);
  assign stat_src    = (csr_addr == A_M_STAT) ? csr_wdata
                     : ((status_q & ~SVIEW_MASK) | (csr_wdata & SVIEW_MASK));
  assign stat_new    = (status_q & ~STAT_WMASK) | (stat_src & STAT_WMASK);
  assign tlb_flush   = flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0; ie_q <= '0; ipsw_q <= '0; ideleg_q <= '0; edeleg_q <= '0;
      mvec_q <= '0; svec_q <= '0; mscr_q <= '0; mepc_q <= '0; mcau_q <= '0;
      mtval_q <= '0; sscr_q <= '0; sepc_q <= '0; scau_q <= '0; stval_q <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= stat_wr && (((stat_new ^ status_q) & XLATE_MASK) != '0);
      if (stat_wr) status_q <= stat_new;
      if (wr) begin
        case (csr_addr)
          A_M_IE:   ie_q     <= csr_wdata & IE_MASK;
          A_S_IE:   ie_q     <= (ie_q & ~ideleg_q) | (csr_wdata & ideleg_q);
          A_M_IP:   ipsw_q   <= csr_wdata & IPSW_MASK;
          A_S_IP:   ipsw_q   <= (ipsw_q & ~(SSIP_BIT & ideleg_q)) | (csr_wdata & SSIP_BIT & ideleg_q);
          A_M_IDEL: ideleg_q <= csr_wdata & DELEG_MASK;
          A_M_EDEL: edeleg_q <= csr_wdata & EDEL_MASK;
          A_M_VEC:  mvec_q   <= csr_wdata & ~XLEN'(2);
          A_S_VEC:  svec_q   <= csr_wdata & ~XLEN'(3);
          A_M_SCR:  mscr_q   <= csr_wdata;
          A_M_EPC:  mepc_q   <= csr_wdata;
          A_M_CAU:  mcau_q   <= csr_wdata;
          A_M_TVAL: mtval_q  <= csr_wdata;
          A_S_SCR:  sscr_q   <= csr_wdata;
          A_S_EPC:  sepc_q   <= csr_wdata;
          A_S_CAU:  scau_q   <= csr_wdata;
          A_S_TVAL: stval_q  <= csr_wdata;
          default: ;
        endcase
      end
    end
  end

  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(csr_valid && csr_we && (csr_addr == A_M_STAT || csr_addr == A_S_STAT)));

  // R5
  ext_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_EXT != 0) || (status_q[16:15] == 2'b00));

  // R8
  sip_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_addr == A_S_IP) |-> ((csr_rdata & ~ideleg_q) == '0));

  // R9
  mvec_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_we && csr_addr == A_M_VEC) |=> (mvec_q[1] == 1'b0));

  // R11
  illegal_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_we && csr_illegal) |=> ($stable(status_q) && $stable(ie_q) && $stable(ipsw_q)));
endmodule

// File: tb/priv_csr_unit_tb.sv
module priv_csr_unit_tb_top;
  localparam int XLEN = 32;
  localparam logic [31:0] STAT_W  = 32'h007E79AA, EXT_F = 32'h00018000, SVIEW = 32'h0005E122;
  localparam logic [31:0] SD_BIT  = 32'h80000000;

  logic clk = 0, rst_n = 0;
  logic csr_valid = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic hw_msip = 0, hw_mtip = 0, hw_seip = 0, hw_meip = 0;
  logic [31:0] rd0, rd1;
  logic ill0, ill1, fl0, fl1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  priv_csr_unit #(.XLEN(XLEN), .HAS_EXT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rd0), .csr_illegal(ill0), .hw_msip(hw_msip),
    .hw_mtip(hw_mtip), .hw_seip(hw_seip), .hw_meip(hw_meip), .tlb_flush(fl0));
  priv_csr_unit #(.XLEN(XLEN), .HAS_EXT(1)) dut_ext_i (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rd1), .csr_illegal(ill1), .hw_msip(hw_msip),
    .hw_mtip(hw_mtip), .hw_seip(hw_seip), .hw_meip(hw_meip), .tlb_flush(fl1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_valid = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_valid = 0; csr_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    csr_valid = 1; csr_we = 0; csr_addr = a;
    #1 r0 = rd0; r1 = rd1;
    @(negedge clk);
    csr_valid = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 flush", {31'b0, fl0}, 0);
    foreach (a0[i]) if (i < 1) ;
    begin
      logic [11:0] regs [18] = '{12'h100,12'h104,12'h105,12'h140,12'h141,12'h142,12'h143,12'h144,
                                 12'h300,12'h302,12'h303,12'h304,12'h305,12'h340,12'h341,12'h342,12'h343,12'h344};
      for (int i = 0; i < 18; i++) begin
        rd(regs[i], a0, a1);
        chk("R1 reset value", a0, 0);
      end
    end

    // R3 walking bits on delegation and enable
    for (int b = 0; b < 32; b++) begin
      wr(12'h303, 32'h1 << b); rd(12'h303, a0, a1); chk("R3 deleg", a0, (32'h1 << b) & 32'h222);
      wr(12'h304, 32'h1 << b); rd(12'h304, a0, a1); chk("R3 enable", a0, (32'h1 << b) & 32'h2AA);
    end

    // R10 exception delegation
    wr(12'h302, 32'hFFFFFFFF); rd(12'h302, a0, a1); chk("R10 edeleg", a0, 32'hBBFF);

    // R2 pending: software bits then hardware lines
    wr(12'h344, 32'hFFFFFFFF); rd(12'h344, a0, a1); chk("R2 sw bits", a0, 32'h22);
    hw_msip = 1; rd(12'h344, a0, a1); chk("R2 msip", a0, 32'h2A); hw_msip = 0;
    hw_mtip = 1; rd(12'h344, a0, a1); chk("R2 mtip", a0, 32'hA2); hw_mtip = 0;
    hw_seip = 1; rd(12'h344, a0, a1); chk("R2 seip", a0, 32'h222); hw_seip = 0;
    hw_meip = 1; rd(12'h344, a0, a1); chk("R2 meip", a0, 32'h822); hw_meip = 0;
    wr(12'h344, 32'h0); rd(12'h344, a0, a1); chk("R2 clear", a0, 0);

    // R8 supervisor windows across delegation patterns
    begin
      logic [31:0] pats [4] = '{32'h0, 32'h2, 32'h20, 32'h222};
      for (int p = 0; p < 4; p++) begin
        wr(12'h303, pats[p]);
        wr(12'h304, 32'h0); wr(12'h344, 32'h0);
        wr(12'h104, 32'hFFFFFFFF);
        rd(12'h304, a0, a1); chk("R8 sie write", a0, pats[p]);
        rd(12'h104, a0, a1); chk("R8 sie read", a0, pats[p]);
        wr(12'h304, 32'h2AA);
        rd(12'h104, a0, a1); chk("R8 sie mask", a0, pats[p]);
        wr(12'h144, 32'hFFFFFFFF);
        rd(12'h344, a0, a1); chk("R8 sip write", a0, pats[p] & 32'h2);
        wr(12'h344, 32'h22); hw_seip = 1;
        rd(12'h144, a0, a1); chk("R8 sip read", a0, (32'h222) & pats[p]);
        hw_seip = 0;
      end
    end

    // R4 R5 status mask, derived dirty bit
    wr(12'h300, 32'hFFFFFFFF);
    rd(12'h300, a0, a1);
    chk("R4 status all ones", a0, STAT_W | SD_BIT);
    chk("R5 status ext", a1, STAT_W | EXT_F | SD_BIT);
    wr(12'h300, SD_BIT); rd(12'h300, a0, a1);
    chk("R4 sd not stored", a0, 0);
    wr(12'h300, 32'h00006000); rd(12'h300, a0, a1);
    chk("R4 fs dirty", a0, 32'h6000 | SD_BIT);
    wr(12'h300, EXT_F); rd(12'h300, a0, a1);
    chk("R5 xs base", a0, 0);
    chk("R5 xs ext", a1, EXT_F | SD_BIT);
    wr(12'h300, 32'h00008000); rd(12'h300, a0, a1);
    chk("R5 xs partial", a1, 32'h8000);

    // R7 supervisor status view
    wr(12'h300, 32'hFFFFFFFF); rd(12'h100, a0, a1);
    chk("R7 sstatus read", a0, (STAT_W & SVIEW) | SD_BIT);
    chk("R7 sstatus read ext", a1, ((STAT_W | EXT_F) & SVIEW) | SD_BIT);
    wr(12'h300, 32'h0); wr(12'h100, 32'hFFFFFFFF); rd(12'h300, a0, a1);
    chk("R7 sstatus write", a0, (STAT_W & SVIEW) | SD_BIT);
    chk("R7 sstatus write ext", a1, ((STAT_W | EXT_F) & SVIEW) | SD_BIT);

    // R6 flush sweep over single status bits, set and clear
    wr(12'h300, 32'h0);
    for (int b = 0; b < 32; b++) begin
      logic exp_f;
      exp_f = (b == 11 || b == 12 || b == 17 || b == 18 || b == 19);
      wr(12'h300, 32'h1 << b);
      chk("R6 flush on set", {31'b0, fl0}, {31'b0, exp_f});
      @(negedge clk);
      chk("R6 flush one cycle", {31'b0, fl0}, 0);
      wr(12'h300, 32'h0);
      chk("R6 flush on clear", {31'b0, fl0}, {31'b0, exp_f});
    end
    wr(12'h100, 32'h00040000);
    chk("R6 flush via sview", {31'b0, fl0}, 1);
    wr(12'h100, 32'h00040000);
    chk("R6 no change no flush", {31'b0, fl0}, 0);

    // R9 vectors
    wr(12'h305, 32'hFFFFFFFF); rd(12'h305, a0, a1); chk("R9 mvec", a0, 32'hFFFFFFFD);
    wr(12'h105, 32'hFFFFFFFF); rd(12'h105, a0, a1); chk("R9 svec", a0, 32'hFFFFFFFC);

    // R12 plain registers
    begin
      logic [11:0] pl [8] = '{12'h140,12'h141,12'h142,12'h143,12'h340,12'h341,12'h342,12'h343};
      for (int i = 0; i < 8; i++) wr(pl[i], 32'hA5C30000 ^ (32'(i) * 32'h01010101));
      for (int i = 0; i < 8; i++) begin
        rd(pl[i], a0, a1); chk("R12 plain", a0, 32'hA5C30000 ^ (32'(i) * 32'h01010101));
      end
    end

    // R11 unimplemented numbers
    wr(12'h300, 32'h00000008); wr(12'h304, 32'h8);
    begin
      logic [11:0] bad [4] = '{12'h301, 12'h3A0, 12'h7C0, 12'hFFF};
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        csr_valid = 1; csr_we = 1; csr_addr = bad[i]; csr_wdata = 32'hFFFFFFFF;
        #1 chk("R11 illegal flag", {31'b0, ill0}, 1);
        chk("R11 rdata zero", rd0, 0);
        @(negedge clk);
        csr_valid = 0; csr_we = 0;
        chk("R11 no flush", {31'b0, fl0}, 0);
        rd(12'h300, a0, a1); chk("R11 status kept", a0, 32'h8);
        rd(12'h304, a0, a1); chk("R11 enable kept", a0, 32'h8);
      end
    end
    @(negedge clk); csr_valid = 1; csr_addr = 12'h300;
    #1 chk("R11 legal flag low", {31'b0, ill0}, 0);
    @(negedge clk); csr_valid = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule